// File: doc/BRIEF.md
# Preamble-Locked Data Clock Recovery

This block recovers a bit clock and retimed data from a single-bit baseband stream that has already been filtered and sliced. A free-running phase accumulator advances on an oversampling tick and wraps once per nominal bit. Every data edge is measured against the expected edge position, and the loop pulls its phase toward that edge. The training pattern is a preamble of alternating ones and zeros. After enough consecutive edges land close to the expected position, the block declares lock. It then delivers one retimed bit per bit period, together with a one-cycle valid strobe.

Two acquisition modes trade settling time against timing precision. Slow mode applies a small correction per edge and needs a longer run of well-placed edges. Fast mode applies a large correction and locks after a short run. Once locked, both modes track with the small correction. The recovered clock reaches its output pin only when the digital-filter path is selected. If the line stays quiet for a long run of bit periods, the block drops lock and starts acquisition again.

Top module: `preamble_cdr`

## Requirements
- R1: A synchronous active-high reset clears lock, the phase accumulator, the acquisition and idle counters, the retimed data and the valid strobe. Recovered clock, data, valid and lock all read 0 while reset is applied and right after it is released, whatever their state before.
- R2: In slow mode (`fast_mode`=0), the lock output goes high in the cycle after the 8th consecutive edge that falls inside the window. An alternating preamble aligned to phase 0 therefore locks on its 8th edge.
- R3: In fast mode (`fast_mode`=1), the lock output goes high in the cycle after the 4th consecutive in-window edge.
- R4: The phase error is the accumulator value at the tick where a new input value is first seen, read as a signed 4-bit number. An edge is in the window when that error lies in −2..+2, both ends included. Before lock, an edge outside the window sets the count of consecutive edges back to zero.
- R5: Before lock, every edge shifts the phase by minus the error arithmetically shifted right by 1 in fast mode, or by 3 in slow mode. For example, an error of +6 costs 3 ticks in fast mode and none in slow mode.
- R6: While locked, edges use the slow-mode shift of 3 whatever `fast_mode` says.
- R7: When 32 consecutive phase wraps (phase 15 to 0) pass with no edge, the block drops lock and clears its acquisition count in the cycle after the 32nd wrap.
- R8: At the tick where the phase equals 8 (mid-bit), the input is captured on `dout_o`. `dvalid_o` pulses high for exactly one reference cycle after that tick, and only if lock was high at that tick.
- R9: When `dig_filt` is 1, `rclk_o` is high while the phase is in 8..15 and low while it is in 0..7. When `dig_filt` is 0, `rclk_o` stays 0.
- R10: An oversampling tick occurs once every `bit_div`+1 reference cycles, the first one `bit_div` cycles after reset. The phase, edge detection, wraps and sampling advance only on ticks, so one bit lasts 16×(`bit_div`+1) reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Filtered serial baseband data |
| bit_div | input | 8 | Reference cycles per oversampling tick, minus one |
| fast_mode | input | 1 | 1 selects fast acquisition, 0 selects slow |
| dig_filt | input | 1 | 1 selects the digital-filter path and enables `rclk_o` |
| rclk_o | output | 1 | Recovered bit clock, rising at mid-bit |
| dout_o | output | 1 | Retimed data bit |
| dvalid_o | output | 1 | One-cycle strobe for each retimed bit while locked |
| locked_o | output | 1 | Lock indicator |

## Verification
Every result is due a fixed number of reference cycles after the tick that causes it. Lock rises or falls one cycle after the tick that holds the deciding edge or wrap. Data and valid appear one cycle after the mid-bit tick. `rclk_o` follows the phase register, so it shows the phase written at the previous tick. The bench numbers every rising clock edge from reset release and derives each due cycle from the tick index and `bit_div`. It then samples at the falling edge just before and just after that cycle, so each check also proves the result does not arrive one cycle early.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    localparam int OSR_DEF       = 16;
    localparam int DIV_W_DEF     = 8;
    localparam int WIN_DEF       = 2;
    localparam int FAST_SH_DEF   = 1;
    localparam int SLOW_SH_DEF   = 3;
    localparam int FAST_LOCK_DEF = 4;
    localparam int SLOW_LOCK_DEF = 8;
    localparam int IDLE_DEF      = 32;

    typedef enum logic {
        ACQ_SLOW = 1'b0,
        ACQ_FAST = 1'b1
    } acq_mode_e;

    // Per-tick events produced by the phase loop.
    typedef struct packed {
        logic edge_hit;
        logic in_win;
        logic wrap;
        logic mid;
    } loop_evt_t;

    function automatic logic within_window(input int err, input int win);
        return (err >= -win) && (err <= win);
    endfunction

endpackage

// File: rtl/cdr_tick_gen.sv
module cdr_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // >= keeps the divider sane if div shrinks below the running count
    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R10: between ticks the count only climbs by one
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cdr_phase_loop.sv
module cdr_phase_loop
    import cdr_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int WIN     = 2,
    parameter int FAST_SH = 1,
    parameter int SLOW_SH = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    din,
    input  logic                    fast_gain,
    output logic [$clog2(OSR)-1:0]  phase_q,
    output loop_evt_t               evt
);

    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR / 2);

    logic                   prev_q;
    logic signed [PH_W-1:0] err;
    logic signed [PH_W-1:0] corr;
    logic        [PH_W-1:0] corr_u;
    logic        [PH_W-1:0] phase_nxt;

    // Ideal edge sits at phase 0; the phase value itself is the signed error.
    assign err = $signed(phase_q);

    always_comb begin
        if (fast_gain) corr = err >>> FAST_SH;
        else           corr = err >>> SLOW_SH;
        corr_u = $unsigned(corr);
    end

    always_comb begin
        evt.edge_hit = tick && (din != prev_q);
        evt.in_win   = within_window(int'(err), WIN);
        evt.wrap     = tick && (phase_q == PH_LAST);
        evt.mid      = tick && (phase_q == PH_MID);
    end

    always_comb begin
        if (evt.edge_hit) phase_nxt = phase_q + PH_ONE - corr_u;
        else              phase_nxt = phase_q + PH_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            prev_q  <= 1'b0;
        end else if (tick) begin
            phase_q <= phase_nxt;
            prev_q  <= din;
        end
    end

    // R10: phase only moves on an oversampling tick
    a_r10_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> $stable(phase_q));

    // R5: a tick without an edge advances the phase by exactly one
    a_r5_free_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && !$past(evt.edge_hit))
            |-> (phase_q == $past(phase_q) + PH_ONE));

endmodule

// File: rtl/cdr_lock_ctl.sv
module cdr_lock_ctl
    import cdr_pkg::*;
#(
    parameter int SLOW_LOCK = 8,
    parameter int FAST_LOCK = 4,
    parameter int IDLE_BITS = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_hit,
    input  logic      in_win,
    input  logic      wrap,
    input  acq_mode_e mode,
    output logic      locked
);

    localparam int CNT_W  = $clog2(SLOW_LOCK + 1);
    localparam int IDLE_W = $clog2(IDLE_BITS);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_BITS - 1);

    logic [CNT_W-1:0]  acq_cnt;
    logic [CNT_W-1:0]  need;
    logic [CNT_W-1:0]  acq_inc;
    logic [IDLE_W-1:0] idle_cnt;

    assign need    = (mode == ACQ_FAST) ? CNT_W'(FAST_LOCK) : CNT_W'(SLOW_LOCK);
    assign acq_inc = acq_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            acq_cnt  <= '0;
            idle_cnt <= '0;
        end else if (edge_hit) begin
            idle_cnt <= '0;
            if (!locked) begin
                if (!in_win) begin
                    acq_cnt <= '0;
                end else if (acq_inc >= need) begin
                    locked  <= 1'b1;
                    acq_cnt <= '0;
                end else begin
                    acq_cnt <= acq_inc;
                end
            end
        end else if (wrap) begin
            if (idle_cnt == IDLE_LAST) begin
                locked   <= 1'b0;
                acq_cnt  <= '0;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    // R2 / R3: lock only rises on an in-window edge
    a_r2_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(edge_hit && in_win));

    // R7: outside reset, lock only falls after a quiet wrap
    a_r7_drop_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(wrap && !edge_hit));

    // R4: the run count never reaches the largest threshold
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        acq_cnt < CNT_W'(SLOW_LOCK));

endmodule

// File: rtl/cdr_retime.sv
module cdr_retime (
    input  logic clk,
    input  logic rst,
    input  logic mid,
    input  logic din,
    input  logic locked,
    input  logic dig_sel,
    input  logic phase_msb,
    output logic rclk,
    output logic dout,
    output logic dvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= 1'b0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= mid && locked;
            if (mid) dout <= din;
        end
    end

    // Second half of the bit is high, so the rising edge marks mid-bit.
    assign rclk = dig_sel && phase_msb;

    // R8: strobe is a single-cycle pulse
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        dvalid |=> !dvalid);

    // R8: strobe needs lock on the sampling cycle
    a_r8_valid_locked: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> $past(locked));

endmodule

// File: rtl/preamble_cdr.sv
module preamble_cdr
    import cdr_pkg::*;
#(
    parameter int OSR       = OSR_DEF,
    parameter int DIV_W     = DIV_W_DEF,
    parameter int WIN       = WIN_DEF,
    parameter int FAST_SH   = FAST_SH_DEF,
    parameter int SLOW_SH   = SLOW_SH_DEF,
    parameter int FAST_LOCK = FAST_LOCK_DEF,
    parameter int SLOW_LOCK = SLOW_LOCK_DEF,
    parameter int IDLE_BITS = IDLE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             fast_mode,
    input  logic             dig_filt,
    output logic             rclk_o,
    output logic             dout_o,
    output logic             dvalid_o,
    output logic             locked_o
);

    localparam int PH_W = $clog2(OSR);

    logic            tick;
    logic [PH_W-1:0] phase;
    loop_evt_t       evt;
    acq_mode_e       mode;
    logic            fast_gain;
    logic            locked;
    logic            ev_edge, ev_win, ev_wrap, ev_mid;

    assign mode      = fast_mode ? ACQ_FAST : ACQ_SLOW;
    // Tracking after lock always uses the gentle gain.
    assign fast_gain = (mode == ACQ_FAST) && !locked;

    assign ev_edge = evt.edge_hit;
    assign ev_win  = evt.in_win;
    assign ev_wrap = evt.wrap;
    assign ev_mid  = evt.mid;

    cdr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (bit_div),
        .tick (tick)
    );

    cdr_phase_loop #(
        .OSR     (OSR),
        .WIN     (WIN),
        .FAST_SH (FAST_SH),
        .SLOW_SH (SLOW_SH)
    ) u_loop (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .din       (din),
        .fast_gain (fast_gain),
        .phase_q   (phase),
        .evt       (evt)
    );

    cdr_lock_ctl #(
        .SLOW_LOCK (SLOW_LOCK),
        .FAST_LOCK (FAST_LOCK),
        .IDLE_BITS (IDLE_BITS)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (ev_edge),
        .in_win   (ev_win),
        .wrap     (ev_wrap),
        .mode     (mode),
        .locked   (locked)
    );

    cdr_retime u_retime (
        .clk       (clk),
        .rst       (rst),
        .mid       (ev_mid),
        .din       (din),
        .locked    (locked),
        .dig_sel   (dig_filt),
        .phase_msb (phase[PH_W-1]),
        .rclk      (rclk_o),
        .dout      (dout_o),
        .dvalid    (dvalid_o)
    );

    assign locked_o = locked;

endmodule

// File: tb/preamble_cdr_test.sv
`timescale 1ns/1ps
module preamble_cdr_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [7:0] bit_div = 8'd0;
    logic       fast_mode = 1'b0;
    logic       dig_filt = 1'b1;
    logic       rclk_o, dout_o, dvalid_o, locked_o;

    int n_chk  = 0;
    int n_fail = 0;
    int c      = 0;   // index of the next rising edge since reset release
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    preamble_cdr uut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .bit_div   (bit_div),
        .fast_mode (fast_mode),
        .dig_filt  (dig_filt),
        .rclk_o    (rclk_o),
        .dout_o    (dout_o),
        .dvalid_o  (dvalid_o),
        .locked_o  (locked_o)
    );

    // Stimulus table: mode, divider, cycle of the edge that completes lock.
    localparam int NVEC = 6;
    localparam int VEC_FAST [NVEC] = '{0, 1, 0, 1, 1, 0};
    localparam int VEC_DIV  [NVEC] = '{0, 0, 1, 2, 1, 3};
    localparam int VEC_LOCK [NVEC] = '{112, 48, 225, 146, 97, 451};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at c=%0d: actual %0d expected %0d", req, c, act, exp);
        end
    endtask

    task automatic step(input logic d);
        din = d;
        @(negedge clk);
        c++;
    endtask

    function automatic logic pre_bit(input int b);
        return (b % 2) == 0;
    endfunction

    task automatic do_reset(input logic f, input int d, input logic dg);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        fast_mode = f;
        bit_div = 8'(d);
        dig_filt = dg;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 lock", int'(locked_o), 0);
        chk("R1 valid", int'(dvalid_o), 0);
        chk("R1 data", int'(dout_o), 0);
        chk("R1 rclk", int'(rclk_o), 0);
        rst = 1'b0;
        c = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // ---------- table walk: lock timing, retimed data, strobe ----------
        for (int v = 0; v < NVEC; v++) begin
            int k, d, cl, cm, cm2;
            d   = VEC_DIV[v];
            k   = VEC_FAST[v] ? 4 : 8;
            cl  = VEC_LOCK[v];
            cm  = (16 * k + 8) * (d + 1) + d;
            cm2 = (16 * (k + 1) + 8) * (d + 1) + d;
            do_reset(VEC_FAST[v] != 0, d, 1'b1);
            while (c <= cm2 + 2) begin
                if (c == cl)      chk(VEC_FAST[v] ? "R3 R10 no early lock" : "R2 R10 no early lock", int'(locked_o), 0);
                if (c == cl + 1)  chk(VEC_FAST[v] ? "R3 R10 lock"          : "R2 R10 lock",          int'(locked_o), 1);
                if (c == cm + 1)  begin chk("R8 valid", int'(dvalid_o), 1); chk("R8 data", int'(dout_o), int'(pre_bit(k))); end
                if (c == cm + 2)  chk("R8 valid one cycle", int'(dvalid_o), 0);
                if (c == cm2 + 1) chk("R8 next data", int'(dout_o), int'(pre_bit(k + 1)));
                step(pre_bit((c / (d + 1)) / 16));
            end
        end

        // ---------- R9: recovered clock shape and gating ----------
        do_reset(1'b0, 0, 1'b1);
        while (c <= 17) begin
            if (c == 7)  chk("R9 rclk low half", int'(rclk_o), 0);
            if (c == 8)  chk("R9 rclk rises mid-bit", int'(rclk_o), 1);
            if (c == 15) chk("R9 rclk high half", int'(rclk_o), 1);
            if (c == 16) chk("R9 rclk falls at wrap", int'(rclk_o), 0);
            step(pre_bit(c / 16));
        end
        do_reset(1'b0, 0, 1'b0);
        while (c <= 12) begin
            if (c == 8 || c == 12) chk("R9 rclk gated off", int'(rclk_o), 0);
            step(pre_bit(c / 16));
        end

        // ---------- R5: acquisition gain, edge with error +6 ----------
        do_reset(1'b1, 0, 1'b1);
        while (c <= 12) begin
            if (c == 10) chk("R5 fast gain rclk", int'(rclk_o), 0);
            if (c == 11) chk("R5 fast gain rclk", int'(rclk_o), 1);
            step(c >= 6);
        end
        do_reset(1'b0, 0, 1'b1);
        while (c <= 9) begin
            if (c == 7) chk("R5 slow gain rclk", int'(rclk_o), 0);
            if (c == 8) chk("R5 slow gain rclk", int'(rclk_o), 1);
            step(c >= 6);
        end

        // ---------- R6: locked in fast mode keeps the slow gain ----------
        do_reset(1'b1, 0, 1'b1);
        while (c <= 90) begin
            if (c == 87) begin chk("R6 still locked", int'(locked_o), 1); chk("R6 tracking gain", int'(rclk_o), 0); end
            if (c == 88) chk("R6 tracking gain", int'(rclk_o), 1);
            step(c < 80 ? pre_bit(c / 16) : (c < 86 ? 1'b1 : 1'b0));
        end
        // R1: reset after lock clears it (checked inside do_reset)

        // ---------- R4: out-of-window edge restarts the run ----------
        do_reset(1'b1, 0, 1'b1);
        while (c <= 100) begin
            if (c == 67) chk("R4 run restarted", int'(locked_o), 0);
            if (c == 98) chk("R4 no early lock", int'(locked_o), 0);
            if (c == 99) chk("R4 lock after restart", int'(locked_o), 1);
            step(c < 16 ? 1'b1 : c < 37 ? 1'b0 : c < 50 ? 1'b1 :
                 c < 66 ? 1'b0 : c < 82 ? 1'b1 : c < 98 ? 1'b0 : 1'b1);
        end

        // ---------- R4: error of +2 is still inside the window ----------
        do_reset(1'b1, 0, 1'b1);
        while (c <= 51) begin
            if (c == 49) chk("R4 window edge no early lock", int'(locked_o), 0);
            if (c == 50) chk("R4 window edge counted", int'(locked_o), 1);
            step(c < 16 ? 1'b1 : c < 34 ? 1'b0 : c < 49 ? 1'b1 : 1'b0);
        end

        // ---------- R7: silence drops lock; R8: no strobe after ----------
        do_reset(1'b1, 0, 1'b1);
        while (c <= 570) begin
            if (c == 49)  chk("R7 locked", int'(locked_o), 1);
            if (c == 553) chk("R8 valid while locked", int'(dvalid_o), 1);
            if (c == 559) chk("R7 lock held through 31 wraps", int'(locked_o), 1);
            if (c == 560) chk("R7 lock dropped", int'(locked_o), 0);
            if (c == 569) chk("R8 no valid unlocked", int'(dvalid_o), 0);
            step(c < 64 ? pre_bit(c / 16) : 1'b0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule